// File: doc/BRIEF.md
# Timer Compare-Match Output Unit

This unit stores a compare value and checks it against the count of an external timer on every clock cycle. The timer is the same width as the compare value, 16 bits by default. When the count becomes equal to the stored value, the unit carries out the action chosen by a 4-bit mode code. The action can toggle, set or clear an output latch. It can also raise a special event, which asks the timer to restart from zero and may start an ADC conversion. A further mode raises only an interrupt. Every active mode sets a sticky interrupt flag, which software clears with a strobe.

Software reaches the unit through a small write port with two addresses. Address 0 is the control register, whose mode code sits in data bits 3:0. Address 1 is the compare value. The output latch is meant to drive a pin. The output-enable tells the pin logic whether this unit owns the pin in the current mode. The timer, pin multiplexing and ADC sit outside the unit and consume its request outputs.

A match fires only on the cycle where equality begins. A timer that stops at the compare value therefore triggers the action once.

Top module: `cmp_match_unit`

## Requirements
- R1: After a synchronous reset the mode is 0000 and the compare value is 0. All outputs (`out_latch`, `out_en`, `irq_flag`, `tmr_reset`, `adc_start`) are 0. No action occurs while the count differs from the compare value.
- R2: In mode 0010, a match inverts `out_latch`, and `out_en` is 1.
- R3: In mode 1000, writing the mode loads `out_latch` with 0 and a match sets it to 1. In mode 1001, writing the mode loads `out_latch` with 1 and a match clears it to 0. In both modes `out_en` is 1.
- R4: In any active mode (0010, 1000, 1001, 1010, 1011), a match sets `irq_flag`. The flag then stays at 1 until `flag_clr` is high at a clock edge. A match and `flag_clr` at the same edge leave the flag at 1.
- R5: In mode 1011, a match drives `tmr_reset` high for exactly one cycle, so the timer can restart at 0x0000. `out_latch` is unchanged and `out_en` is 0.
- R6: With parameter `ADC_START_EN` = 1, a mode-1011 match drives `adc_start` high for the same single cycle as `tmr_reset`. This happens only if `adc_enable` is 1 at the match. Otherwise `adc_start` stays 0.
- R7: In mode 1010, `out_en` is 0 and `out_latch` is unchanged by a match. Only `irq_flag` is set.
- R8: A match acts once per equality event. A count held at the compare value on later cycles causes no further action.
- R9: Writing 0 to the control register forces `out_latch` and `out_en` to 0. Mode 0000 and any unlisted code (for example 0101) take no action on a match and leave `irq_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control (mode in bits 3:0), 1 = compare value |
| wr_data | input | CNT_W | Write data |
| flag_clr | input | 1 | Clears the interrupt flag |
| tmr_count | input | CNT_W | Current count of the external timer |
| adc_enable | input | 1 | ADC is powered; gates the conversion request |
| out_latch | output | 1 | Compare output latch |
| out_en | output | 1 | Unit owns the output pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| tmr_reset | output | 1 | One-cycle request to zero the timer |
| adc_start | output | 1 | One-cycle request to start an ADC conversion |

## Verification
Every result is registered, so it appears one rising edge after the stimulus that causes it. This holds for a count that becomes equal, a register write and a flag clear alike. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which places each check half a cycle after the edge that updates the result. Single-cycle pulses and held equality are checked over the following cycle as well. This confirms that `tmr_reset` and `adc_start` fall again and that the latch does not move a second time.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_TOG = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_SET = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLR = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_SWI = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_SEV = 4'b1011;

  // Mode produces an action (and an interrupt) on a match.
  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return (m == MODE_TOG) || (m == MODE_SET) || (m == MODE_CLR) ||
           (m == MODE_SWI) || (m == MODE_SEV);
  endfunction

  // Mode takes ownership of the output pin.
  function automatic logic mode_owns_pin(input logic [MODE_W-1:0] m);
    return (m == MODE_TOG) || (m == MODE_SET) || (m == MODE_CLR);
  endfunction
endpackage

// File: rtl/cmu_regs.sv
module cmu_regs
  import cmu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              ctrl_wr,
  output logic [MODE_W-1:0] ctrl_new,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  cmp_q
);
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CMP  = 1'b1;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign ctrl_new = wr_data[MODE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_OFF;
      cmp_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL) mode_q <= ctrl_new;
      if (wr_addr == ADDR_CMP)  cmp_q  <= wr_data;
    end
  end
endmodule

// File: rtl/cmu_match_det.sv
module cmu_match_det
  import cmu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic [CNT_W-1:0]  count,
  input  logic [MODE_W-1:0] mode,
  input  logic              ctrl_wr,
  output logic              fire
);
  logic eq_now;
  logic eq_prev;
  logic rise;

  assign eq_now = (cmp_val == count);
  assign rise   = eq_now && !eq_prev;
  // A control write owns that cycle; a coincident match is dropped.
  assign fire   = rise && mode_active(mode) && !ctrl_wr;

  always_ff @(posedge clk) begin
    if (rst) eq_prev <= 1'b0;
    else     eq_prev <= eq_now;
  end

  // R8: an equality onset cannot repeat on the very next cycle
  assert_single_onset_R8: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/cmu_action.sv
module cmu_action
  import cmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [MODE_W-1:0] ctrl_new,
  input  logic [MODE_W-1:0] mode,
  input  logic              fire,
  output logic              out_latch,
  output logic              out_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_latch <= 1'b0;
      out_en    <= 1'b0;
    end else if (ctrl_wr) begin
      out_en <= mode_owns_pin(ctrl_new);
      case (ctrl_new)
        MODE_OFF: out_latch <= 1'b0;
        MODE_SET: out_latch <= 1'b0;  // preload opposite level
        MODE_CLR: out_latch <= 1'b1;
        default:  out_latch <= out_latch;
      endcase
    end else if (fire) begin
      case (mode)
        MODE_TOG: out_latch <= !out_latch;
        MODE_SET: out_latch <= 1'b1;
        MODE_CLR: out_latch <= 1'b0;
        default:  out_latch <= out_latch;
      endcase
    end
  end

  assert_zero_ctrl_low_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_new == MODE_OFF) |=> (!out_latch && !out_en));

  assert_swi_latch_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SWI && !ctrl_wr) |=> $stable(out_latch));

  assert_set_on_match_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && mode == MODE_SET) |=> out_latch);

  assert_sev_latch_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SEV && !ctrl_wr) |=> $stable(out_latch));
endmodule

// File: rtl/cmu_event.sv
module cmu_event
  import cmu_pkg::*;
#(
  parameter bit ADC_START_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [MODE_W-1:0] mode,
  input  logic              flag_clr,
  input  logic              adc_enable,
  output logic              irq_flag,
  output logic              tmr_reset,
  output logic              adc_start
);
  logic sev_hit;
  assign sev_hit = fire && (mode == MODE_SEV);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag  <= 1'b0;
      tmr_reset <= 1'b0;
    end else begin
      if (fire)          irq_flag <= 1'b1;  // set beats clear
      else if (flag_clr) irq_flag <= 1'b0;
      tmr_reset <= sev_hit;
    end
  end

  generate
    if (ADC_START_EN) begin : g_adc
      always_ff @(posedge clk) begin
        if (rst) adc_start <= 1'b0;
        else     adc_start <= sev_hit && adc_enable;
      end
    end else begin : g_no_adc
      assign adc_start = 1'b0;
    end
  endgenerate

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
    fire |=> irq_flag);

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !fire) |=> !irq_flag);

  assert_reset_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    tmr_reset |=> !tmr_reset);

  assert_adc_with_reset_R6: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> tmr_reset);
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmu_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter bit ADC_START_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic             adc_enable,
  output logic             out_latch,
  output logic             out_en,
  output logic             irq_flag,
  output logic             tmr_reset,
  output logic             adc_start
);
  logic              ctrl_wr;
  logic [MODE_W-1:0] ctrl_new;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              fire;

  cmu_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ctrl_wr  (ctrl_wr),
    .ctrl_new (ctrl_new),
    .mode_q   (mode_q),
    .cmp_q    (cmp_q)
  );

  cmu_match_det #(.CNT_W(CNT_W)) u_det (
    .clk     (clk),
    .rst     (rst),
    .cmp_val (cmp_q),
    .count   (tmr_count),
    .mode    (mode_q),
    .ctrl_wr (ctrl_wr),
    .fire    (fire)
  );

  cmu_action u_act (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_new  (ctrl_new),
    .mode      (mode_q),
    .fire      (fire),
    .out_latch (out_latch),
    .out_en    (out_en)
  );

  cmu_event #(.ADC_START_EN(ADC_START_EN)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .mode       (mode_q),
    .flag_clr   (flag_clr),
    .adc_enable (adc_enable),
    .irq_flag   (irq_flag),
    .tmr_reset  (tmr_reset),
    .adc_start  (adc_start)
  );

  // R1: an inactive mode never produces an action
  assert_idle_no_fire_R1: assert property (@(posedge clk) disable iff (rst)
    !mode_active(mode_q) |-> !fire);
endmodule

// File: tb/sim_cmp_match_unit.sv
`timescale 1ns/1ps
module sim_cmp_match_unit;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          wr_addr = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic          flag_clr = 1'b0;
  logic [CW-1:0] tmr_count = 16'h5555;
  logic          adc_enable = 1'b0;
  logic          out_latch, out_en, irq_flag, tmr_reset, adc_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_match_unit #(.CNT_W(CW), .ADC_START_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_clr(flag_clr), .tmr_count(tmr_count), .adc_enable(adc_enable),
    .out_latch(out_latch), .out_en(out_en), .irq_flag(irq_flag),
    .tmr_reset(tmr_reset), .adc_start(adc_start)
  );

  // Vector layout: [41:38] mode, [37:22] compare, [21:6] count, [5] adc_enable,
  // [4] latch, [3] enable, [2] flag, [1] timer reset, [0] adc start
  localparam int NV = 9;
  localparam logic [41:0] VEC [NV] = '{
    {4'b0010, 16'h1234, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'b1000, 16'h00FF, 16'h00FF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'b1001, 16'hABCD, 16'hABCD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'b1001, 16'hABCD, 16'hABCC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'b1010, 16'h0040, 16'h0040, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'b1011, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {4'b1011, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'b0101, 16'h0777, 16'h0777, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'b1000, 16'h3000, 16'h2FFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  function automatic string mode_tag(input logic [3:0] m);
    case (m)
      4'b0010: return "R2";
      4'b1000, 4'b1001: return "R3";
      4'b1010: return "R7";
      4'b1011: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic reg_write(input logic addr, input logic [CW-1:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check("R1", "latch after reset", out_latch, 1'b0);
    check("R1", "enable after reset", out_en, 1'b0);
    check("R1", "flag after reset", irq_flag, 1'b0);
    check("R1", "timer reset after reset", tmr_reset, 1'b0);
    check("R1", "adc start after reset", adc_start, 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0]    m;
      logic [CW-1:0] cv;
      logic [CW-1:0] cn;
      m  = VEC[i][41:38];
      cv = VEC[i][37:22];
      cn = VEC[i][21:6];
      tmr_count = cv ^ 16'h8000;
      flag_clr = 1'b1;
      reg_write(1'b0, '0);
      flag_clr = 1'b0;
      reg_write(1'b1, cv);
      reg_write(1'b0, {12'h000, m});
      tick();
      tmr_count  = cn;
      adc_enable = VEC[i][5];
      tick();
      check(mode_tag(m), $sformatf("vec%0d latch", i), out_latch, VEC[i][4]);
      check(mode_tag(m), $sformatf("vec%0d enable", i), out_en, VEC[i][3]);
      check("R4", $sformatf("vec%0d flag", i), irq_flag, VEC[i][2]);
      check("R5", $sformatf("vec%0d timer reset", i), tmr_reset, VEC[i][1]);
      check("R6", $sformatf("vec%0d adc start", i), adc_start, VEC[i][0]);
    end

    // R8: held equality acts once
    flag_clr = 1'b1;
    reg_write(1'b0, '0);
    flag_clr = 1'b0;
    reg_write(1'b1, 16'h0100);
    reg_write(1'b0, 16'h0002);
    tmr_count = 16'h00FF;
    tick();
    tmr_count = 16'h0100;
    tick();
    check("R2", "first toggle", out_latch, 1'b1);
    tick(); tick(); tick();
    check("R8", "held count no retoggle", out_latch, 1'b1);
    tmr_count = 16'h0101;
    tick();
    tmr_count = 16'h0100;
    tick();
    check("R2", "second toggle", out_latch, 1'b0);

    // R4: clear alone, then clear coinciding with a match
    tmr_count = 16'h0101;
    flag_clr = 1'b1;
    tick();
    check("R4", "flag cleared", irq_flag, 1'b0);
    tmr_count = 16'h0100;
    tick();
    flag_clr = 1'b0;
    check("R4", "set wins over clear", irq_flag, 1'b1);
    tick(); tick();
    check("R4", "flag sticky", irq_flag, 1'b1);

    // R9: zero control write forces latch low
    check("R2", "latch high before zero write", out_latch, 1'b1);
    reg_write(1'b0, '0);
    check("R9", "latch after zero write", out_latch, 1'b0);
    check("R9", "enable after zero write", out_en, 1'b0);

    // R5 / R6: pulses last one cycle
    reg_write(1'b1, 16'h2000);
    reg_write(1'b0, 16'h000B);
    tmr_count  = 16'h1FFF;
    adc_enable = 1'b1;
    tick();
    tmr_count = 16'h2000;
    tick();
    check("R5", "timer reset pulse high", tmr_reset, 1'b1);
    check("R6", "adc start pulse high", adc_start, 1'b1);
    tick();
    check("R5", "timer reset pulse ends", tmr_reset, 1'b0);
    check("R6", "adc start pulse ends", adc_start, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule